// File: doc/BRIEF.md
# Delay-Line Tap Edge Encoder

This block turns a captured snapshot of a sampled delay line into a supply-voltage correction code. A pulse is launched into a chain of delay cells, and the taps are latched a fixed fraction of a clock period later. Taps the pulse has already passed read one and taps it has not yet reached read zero. The block is given that 16-bit word, which covers taps 12 through 27 of the line. It finds the first place where the word steps from one to zero. That place is how far the pulse got, and so it is a measure of how fast the logic runs at the present supply.

The distance is compared with a programmable reference position, which is characterised at worst-case supply. The difference is scaled down by an arithmetic right shift and added to a 6-bit default-frequency base code. The result is a 6-bit compensated code for the supply loop. A pulse that never reached the first tap drives the code to its maximum-increase value. A pulse that ran past the last tap drives it to its maximum-decrease value. Each of these cases raises a flag for that one update. The first and last taps are also exported as status monitors.

Top module: `tap_edge_encoder`

## Requirements
- R1: While rst_ni is low, code_o, valid_o, under_o, over_o, first_tap_o and last_tap_o are all 0.
- R2: Bit k of taps_i is delay-line tap 12+k, and the pulse travels from bit 0 toward bit 15. The travel position is p = k+1, where k is the lowest index with taps_i[k]=1 and taps_i[k+1]=0.
- R3: When taps_i[0]=1 and taps_i is not all ones, the result is base_code_i + ((ref_pos_i - p) >>> shift_i), computed as signed arithmetic. A longer travel therefore gives a lower code.
- R4: The scaling is an arithmetic right shift of the signed difference by shift_i (0 to 3), which rounds toward minus infinity. For example, -7 shifted by 1 gives -4.
- R5: In the R3 case, a result below 0 is clamped to 0 and a result above 63 is clamped to 63.
- R6: When taps_i[0]=0, the pulse did not reach the first tap. The code becomes 63, and under_o is high for exactly the one cycle in which valid_o is high.
- R7: When all 16 taps read 1, the pulse passed the last tap. The code becomes 0, and over_o is high for exactly the one cycle in which valid_o is high.
- R8: When the word holds several one-to-zero boundaries, only the lowest-index boundary sets p.
- R9: The outputs update only on the rising clock edge at which valid_i is 1. valid_o is high for the one cycle that follows. code_o, first_tap_o and last_tap_o keep their values when valid_i is 0, whatever the other inputs do.
- R10: On each update, first_tap_o takes the value of taps_i[0] and last_tap_o takes the value of taps_i[15].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe that marks a new tap snapshot |
| taps_i | input | 16 | Captured tap word; bit 0 is the first tap |
| ref_pos_i | input | 5 | Reference travel position |
| base_code_i | input | 6 | Code for the default frequency |
| shift_i | input | 2 | Right-shift amount applied to the error |
| valid_o | output | 1 | Pulse that marks an updated result |
| code_o | output | 6 | Compensated supply code |
| under_o | output | 1 | The pulse did not reach the first tap |
| over_o | output | 1 | The pulse ran past the last tap |
| first_tap_o | output | 1 | First tap from the last snapshot |
| last_tap_o | output | 1 | Last tap from the last snapshot |

## Verification
The hardest cases to reach are words that a real delay line seldom produces. These are snapshots with several one-to-zero boundaries, and snapshots whose ones lie only above a zero first tap. Both decide whether the lowest boundary is used and whether the underflow test really keys on the first tap. The stimulus writes such broken thermometer words on purpose, next to ordinary fills of every length. It combines these with shift amounts that round negative errors, and with base and reference values chosen to force both saturation limits. Between strobes it toggles every data input, to show that the held code does not move.

// File: rtl/tap_enc_pkg.sv
package tap_enc_pkg;
  typedef enum logic [1:0] {
    EDGE_OK    = 2'd0,
    EDGE_UNDER = 2'd1,
    EDGE_OVER  = 2'd2
  } edge_st_e;
endpackage

// File: rtl/tap_edge_find.sv
module tap_edge_find #(
  parameter int N_TAPS = 16,
  parameter int POS_W  = $clog2(N_TAPS + 1)
) (
  input  logic [N_TAPS-1:0]      taps_i,
  output logic [POS_W-1:0]       pos_o,
  output tap_enc_pkg::edge_st_e  st_o
);
  logic [N_TAPS-2:0] bnd;

  for (genvar k = 0; k < N_TAPS - 1; k++) begin : g_bnd
    assign bnd[k] = taps_i[k] & ~taps_i[k+1];
  end

  // scan from the top so that the lowest boundary wins
  always_comb begin
    pos_o = '0;
    for (int k = N_TAPS - 2; k >= 0; k--) begin
      if (bnd[k]) pos_o = POS_W'(k + 1);
    end
  end

  always_comb begin
    if (!taps_i[0])    st_o = tap_enc_pkg::EDGE_UNDER;
    else if (&taps_i)  st_o = tap_enc_pkg::EDGE_OVER;
    else               st_o = tap_enc_pkg::EDGE_OK;
  end
endmodule

// File: rtl/tap_err_scale.sv
module tap_err_scale #(
  parameter int POS_W   = 5,
  parameter int CODE_W  = 6,
  parameter int SHIFT_W = 2
) (
  input  logic [POS_W-1:0]   pos_i,
  input  logic [POS_W-1:0]   ref_i,
  input  logic [CODE_W-1:0]  base_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [CODE_W-1:0]  code_o
);
  localparam int DW = POS_W + 2;
  localparam int SW = ((CODE_W > DW) ? CODE_W : DW) + 2;

  logic signed [DW-1:0] diff;
  logic signed [DW-1:0] diff_sh;
  logic signed [SW-1:0] sum;

  assign diff    = $signed({2'b00, ref_i}) - $signed({2'b00, pos_i});
  assign diff_sh = diff >>> shift_i;
  assign sum     = $signed({{(SW-CODE_W){1'b0}}, base_i})
                 + $signed({{(SW-DW){diff_sh[DW-1]}}, diff_sh});

  always_comb begin
    if (sum[SW-1])                code_o = '0;
    else if (|sum[SW-2:CODE_W])   code_o = '1;
    else                          code_o = sum[CODE_W-1:0];
  end
endmodule

// File: rtl/tap_edge_encoder.sv
module tap_edge_encoder #(
  parameter int N_TAPS  = 16,
  parameter int CODE_W  = 6,
  parameter int SHIFT_W = 2,
  parameter int POS_W   = $clog2(N_TAPS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [N_TAPS-1:0]  taps_i,
  input  logic [POS_W-1:0]   ref_pos_i,
  input  logic [CODE_W-1:0]  base_code_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               valid_o,
  output logic [CODE_W-1:0]  code_o,
  output logic               under_o,
  output logic               over_o,
  output logic               first_tap_o,
  output logic               last_tap_o
);
  import tap_enc_pkg::*;

  logic [POS_W-1:0]  pos;
  edge_st_e          st;
  logic [CODE_W-1:0] scaled;
  logic [CODE_W-1:0] code_d;

  tap_edge_find #(.N_TAPS(N_TAPS), .POS_W(POS_W)) u_find (
    .taps_i (taps_i),
    .pos_o  (pos),
    .st_o   (st)
  );

  tap_err_scale #(.POS_W(POS_W), .CODE_W(CODE_W), .SHIFT_W(SHIFT_W)) u_scale (
    .pos_i   (pos),
    .ref_i   (ref_pos_i),
    .base_i  (base_code_i),
    .shift_i (shift_i),
    .code_o  (scaled)
  );

  always_comb begin
    unique case (st)
      EDGE_UNDER: code_d = '1;
      EDGE_OVER:  code_d = '0;
      default:    code_d = scaled;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      under_o     <= 1'b0;
      over_o      <= 1'b0;
      code_o      <= '0;
      first_tap_o <= 1'b0;
      last_tap_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      under_o <= valid_i && (st == EDGE_UNDER);
      over_o  <= valid_i && (st == EDGE_OVER);
      if (valid_i) begin
        code_o      <= code_d;
        first_tap_o <= taps_i[0];
        last_tap_o  <= taps_i[N_TAPS-1];
      end
    end
  end
endmodule

// File: rtl/tap_edge_encoder_chk.sv
module tap_edge_encoder_chk #(
  parameter int N_TAPS  = 16,
  parameter int CODE_W  = 6,
  parameter int SHIFT_W = 2,
  parameter int POS_W   = $clog2(N_TAPS + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [N_TAPS-1:0]  taps_i,
  input logic               valid_o,
  input logic [CODE_W-1:0]  code_o,
  input logic               under_o,
  input logic               over_o,
  input logic               first_tap_o,
  input logic               last_tap_o
);
  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(code_o) && $stable(first_tap_o) && $stable(last_tap_o));
  p_under_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !taps_i[0]) |=> under_o && (code_o == '1));
  p_over_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (&taps_i)) |=> over_o && (code_o == '0));
  p_flag_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(under_o && over_o));
  p_flag_qual_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (under_o || over_o) |-> valid_o);
  p_last_tap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (last_tap_o == $past(taps_i[N_TAPS-1])) && (first_tap_o == $past(taps_i[0])));
endmodule

bind tap_edge_encoder tap_edge_encoder_chk #(
  .N_TAPS(N_TAPS), .CODE_W(CODE_W), .SHIFT_W(SHIFT_W), .POS_W(POS_W)
) u_chk (.*);

// File: tb/tap_edge_encoder_tb_top.sv
module tap_edge_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] taps_i = '0;
  logic [4:0]  ref_pos_i = '0;
  logic [5:0]  base_code_i = '0;
  logic [1:0]  shift_i = '0;
  logic        valid_o, under_o, over_o, first_tap_o, last_tap_o;
  logic [5:0]  code_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [5:0] code;
    logic       under;
    logic       over;
    logic       first;
    logic       last;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  tap_edge_encoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .taps_i(taps_i),
    .ref_pos_i(ref_pos_i), .base_code_i(base_code_i), .shift_i(shift_i),
    .valid_o(valid_o), .code_o(code_o), .under_o(under_o), .over_o(over_o),
    .first_tap_o(first_tap_o), .last_tap_o(last_tap_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [15:0] t, input int rp, input int b,
                                 input int sh, input string req);
    exp_t e;
    int p, v;
    e.req = req; e.first = t[0]; e.last = t[15]; e.under = 0; e.over = 0;
    if (!t[0]) begin
      e.code = 6'd63; e.under = 1;
    end else if (t == 16'hFFFF) begin
      e.code = 6'd0; e.over = 1;
    end else begin
      p = 0;
      for (int k = 0; k < 15 && p == 0; k++)
        if (t[k] && !t[k+1]) p = k + 1;
      v = b + ((rp - p) >>> sh);
      if (v < 0) v = 0;
      if (v > 63) v = 63;
      e.code = 6'(v);
    end
    return e;
  endfunction

  task automatic drive(input logic [15:0] t, input int rp, input int b,
                       input int sh, input string req);
    @(negedge clk);
    taps_i = t; ref_pos_i = 5'(rp); base_code_i = 6'(b); shift_i = 2'(sh);
    valid_i = 1'b1;
    sb_q.push_back(model(t, rp, b, sh, req));
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor: compare each result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (sb_q.size() == 0) begin
        check("R9 unexpected valid_o", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.req, " code"}, code_o, e.code);
        check({e.req, " under R6"}, under_o, e.under);
        check({e.req, " over R7"}, over_o, e.over);
        check({e.req, " first R10"}, first_tap_o, e.first);
        check({e.req, " last R10"}, last_tap_o, e.last);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0] held;
    repeat (3) @(negedge clk);
    check("R1 code", code_o, 0);
    check("R1 valid", valid_o, 0);
    check("R1 under", under_o, 0);
    check("R1 over", over_o, 0);
    check("R1 taps", {first_tap_o, last_tap_o}, 0);
    rst_n = 1'b1;

    // R2/R3: thermometer fills of every length
    for (int n = 1; n <= 15; n++) drive(16'((32'd1 << n) - 1), 8, 32, 0, "R2 R3");
    drive(16'h0007, 3, 10, 0, "R3 zero error");
    drive(16'h003F, 12, 5, 0, "R3 positive error");
    // R4: arithmetic shift with floor rounding
    drive(16'h01FF, 2, 30, 1, "R4 -7>>>1");
    drive(16'h00FF, 1, 30, 2, "R4 -7>>>2");
    drive(16'h0001, 20, 30, 3, "R4 19>>>3");
    drive(16'h000F, 3, 30, 3, "R4 -1>>>3");
    // R5: saturation
    drive(16'h0001, 31, 60, 0, "R5 high clamp");
    drive(16'h7FFF, 0, 3, 0, "R5 low clamp");
    // R6/R7: out-of-range travel
    drive(16'h0000, 8, 32, 0, "R6 all zero");
    drive(16'hFF00, 8, 32, 0, "R6 first tap low");
    drive(16'hFFFF, 8, 32, 0, "R7 all ones");
    // R8: several boundaries
    drive(16'h0F37, 8, 32, 0, "R8 lowest boundary");
    drive(16'hF0F1, 8, 32, 0, "R8 tap0 only");
    // R10: monitors
    drive(16'h8001, 8, 32, 0, "R10 ends set");

    // R9: hold while strobe idle
    drive(16'h003F, 4, 20, 0, "R9 load");
    @(negedge clk);
    held = code_o;
    taps_i = 16'h0000; ref_pos_i = 5'd31; base_code_i = 6'd63; shift_i = 2'd3;
    repeat (4) @(negedge clk);
    check("R9 hold code", code_o, held);
    check("R9 hold first", first_tap_o, 1);
    check("R9 no valid", valid_o, 0);
    check("R9 no under", under_o, 0);

    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule